// File: doc/BRIEF.md
# Color Palette Processor Access Controller

This block holds a 256-entry color lookup table of 24-bit words and gives it two independent ports. A byte-wide processor port loads and inspects the table, and a display port turns an 8-bit pixel index into a 24-bit color on every clock. The two ports share the storage but nothing else, so processor traffic never stalls or changes the timing of the display lookup.

The processor first writes an 8-bit entry pointer. It then moves the color one byte at a time, red first, then green, then blue, all on the same data bus. A 2-bit color step counter tracks which component comes next. On a write, red and green are held in staging registers, and the full word is committed to the table in one update when blue arrives. After the blue access, the entry pointer moves to the next entry, so a burst can cover the whole table without reloading the pointer. On a read, the whole entry is copied when its red byte is read, and the green and blue bytes are taken from that copy.

Top module: `pal_access_ctrl`

## Requirements
- R1: After reset the entry pointer reads back as 0x00, and the first data write goes to the red component of entry 0.
- R2: A write with cpu_cs=1, cpu_we=1 and cpu_csel=2'b00 loads cpu_wdata into the entry pointer. A read with cpu_csel=2'b00 returns the pointer on cpu_rdata.
- R3: Any access with cpu_csel=2'b00, read or write, returns the color step to red, even in the middle of a sequence.
- R4: Each access with cpu_csel=2'b01 advances the color step red to green to blue and back to red, modulo 3.
- R5: Data writes stage the red and green bytes. Only the blue write changes the table, and it stores the word {red[23:16], green[15:8], blue[7:0]} at the pointed entry.
- R6: After a blue access (read or write), the entry pointer increments, wrapping from 0xFF to 0x00.
- R7: A data read returns the red, green and blue bytes of the pointed entry in step order. cpu_rdata changes at the clock edge that completes the access and holds until the next read.
- R8: Accesses with cpu_csel[1]=1, and any cycle with cpu_cs=0, change neither pointer, the color step nor the table.
- R9: pix_rgb shows the entry selected by pix_idx one clock later. If a blue write hits the same entry in the same cycle, pix_rgb shows the old word, and the new word appears on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_cs | input | 1 | Processor access strobe, one access per high cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_csel | input | 2 | Target: 00 pointer, 01 palette data, others ignored |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 8 | Processor read byte, registered |
| pix_idx | input | 8 | Display pixel index |
| pix_rgb | output | 24 | Display color, one clock after pix_idx |

## Verification
A blue write can commit a new word to the same entry that the display port is reading in that cycle. The bench provokes this by driving pix_idx at an entry and issuing the blue byte on the same falling edge. It then expects the old word on pix_rgb after the next rising edge and the new word one clock later. A second collision is a pointer access that arrives in the middle of a color sequence. It is judged by where the next red, green and blue bytes land in the table.

// File: rtl/pal_pkg.sv
package pal_pkg;

    typedef enum logic [1:0] {
        COL_RED = 2'd0,
        COL_GRN = 2'd1,
        COL_BLU = 2'd2
    } col_e;

    localparam logic [1:0] CSEL_PTR  = 2'b00;
    localparam logic [1:0] CSEL_DATA = 2'b01;

endpackage

// File: rtl/pal_mem.sv
module pal_mem #(
    parameter int IDX_W  = 8,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  cpu_addr,
    output logic [WORD_W-1:0] cpu_word,
    input  logic [IDX_W-1:0]  disp_idx,
    output logic [WORD_W-1:0] disp_word
);
    localparam int DEPTH = 1 << IDX_W;

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [WORD_W-1:0] disp_d, disp_q;

    // processor side: combinational look at the pointed entry
    assign cpu_word = mem_q[cpu_addr];

    always_comb begin
        disp_d = mem_q[disp_idx];
    end

    // read-before-write: a same-cycle write is seen one clock later
    always_ff @(posedge clk) begin
        disp_q <= disp_d;
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign disp_word = disp_q;

endmodule

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int CH_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs,
    input  logic                we,
    input  logic [1:0]          csel,
    input  logic [CH_W-1:0]     wdata,
    output logic [CH_W-1:0]     rdata,
    input  logic [3*CH_W-1:0]   mem_rd_word,
    output logic [IDX_W-1:0]    mem_addr,
    output logic                mem_we,
    output logic [3*CH_W-1:0]   mem_wdata
);
    localparam int WORD_W = 3 * CH_W;

    typedef struct packed {
        logic [IDX_W-1:0]  ptr;
        col_e              sub;
        logic [CH_W-1:0]   red;
        logic [CH_W-1:0]   grn;
        logic [WORD_W-1:0] snap;
        logic [CH_W-1:0]   rdata;
    } seq_t;

    seq_t st_d, st_q;
    logic acc_ptr, acc_dat;

    always_comb begin
        st_d      = st_q;
        mem_we    = 1'b0;
        mem_wdata = {st_q.red, st_q.grn, wdata};
        acc_ptr   = cs && (csel == CSEL_PTR);
        acc_dat   = cs && (csel == CSEL_DATA);

        if (acc_ptr) begin
            st_d.sub = COL_RED;
            if (we) begin
                st_d.ptr = wdata;
            end else begin
                st_d.rdata = st_q.ptr;
            end
        end

        if (acc_dat) begin
            case (st_q.sub)
                COL_RED: st_d.sub = COL_GRN;
                COL_GRN: st_d.sub = COL_BLU;
                default: st_d.sub = COL_RED;
            endcase
            if (we) begin
                case (st_q.sub)
                    COL_RED: st_d.red = wdata;
                    COL_GRN: st_d.grn = wdata;
                    default: mem_we   = 1'b1;
                endcase
            end else begin
                case (st_q.sub)
                    COL_RED: begin
                        st_d.snap  = mem_rd_word;
                        st_d.rdata = mem_rd_word[WORD_W-1 -: CH_W];
                    end
                    COL_GRN: st_d.rdata = st_q.snap[2*CH_W-1 -: CH_W];
                    default: st_d.rdata = st_q.snap[CH_W-1:0];
                endcase
            end
            if (st_q.sub == COL_BLU) begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata    = st_q.rdata;
    assign mem_addr = st_q.ptr;

    AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sub inside {COL_RED, COL_GRN, COL_BLU}); // R4

    AST_PTR_ACC_RST_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && csel == CSEL_PTR) |=> (st_q.sub == COL_RED)); // R3

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && csel == CSEL_PTR) |=> (st_q.ptr == $past(wdata))); // R2

    AST_PTR_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && csel == CSEL_DATA && st_q.sub == COL_BLU)
        |=> (st_q.ptr == IDX_W'($past(st_q.ptr) + 1'b1))); // R6

    AST_IGNORED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && csel[1]) |=> ($stable(st_q.ptr) && $stable(st_q.sub))); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs) |=> ($stable(st_q.ptr) && $stable(st_q.sub) && !$past(mem_we))); // R8

endmodule

// File: rtl/pal_access_ctrl.sv
module pal_access_ctrl
    import pal_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int CH_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_cs,
    input  logic                cpu_we,
    input  logic [1:0]          cpu_csel,
    input  logic [CH_W-1:0]     cpu_wdata,
    output logic [CH_W-1:0]     cpu_rdata,
    input  logic [IDX_W-1:0]    pix_idx,
    output logic [3*CH_W-1:0]   pix_rgb
);
    localparam int WORD_W = 3 * CH_W;

    logic [IDX_W-1:0]  mem_addr;
    logic              mem_we;
    logic [WORD_W-1:0] mem_wdata;
    logic [WORD_W-1:0] mem_rd_word;

    pal_seq #(.IDX_W(IDX_W), .CH_W(CH_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs         (cpu_cs),
        .we         (cpu_we),
        .csel       (cpu_csel),
        .wdata      (cpu_wdata),
        .rdata      (cpu_rdata),
        .mem_rd_word(mem_rd_word),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata)
    );

    pal_mem #(.IDX_W(IDX_W), .WORD_W(WORD_W)) mem_i (
        .clk      (clk),
        .wr_en    (mem_we),
        .wr_addr  (mem_addr),
        .wr_data  (mem_wdata),
        .cpu_addr (mem_addr),
        .cpu_word (mem_rd_word),
        .disp_idx (pix_idx),
        .disp_word(pix_rgb)
    );

    AST_WR_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (cpu_cs && cpu_we && cpu_csel == CSEL_DATA)); // R5

endmodule

// File: tb/pal_access_ctrl_tb.sv
module pal_access_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_cs = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_csel = 2'b00;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic [7:0]  pix_idx = 8'h00;
    logic [23:0] pix_rgb;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pal_access_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_cs   (cpu_cs),
        .cpu_we   (cpu_we),
        .cpu_csel (cpu_csel),
        .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata),
        .pix_idx  (pix_idx),
        .pix_rgb  (pix_rgb)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        cpu_cs = 1'b1; cpu_we = 1'b1; cpu_csel = sel; cpu_wdata = d;
        @(negedge clk);
        cpu_cs = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] sel, output logic [7:0] d);
        @(negedge clk);
        cpu_cs = 1'b1; cpu_we = 1'b0; cpu_csel = sel;
        @(negedge clk);
        cpu_cs = 1'b0;
        d = cpu_rdata;
    endtask

    task automatic disp(input logic [7:0] idx, output logic [23:0] w);
        @(negedge clk);
        pix_idx = idx;
        @(negedge clk);
        w = pix_rgb;
    endtask

    task automatic put_entry(input logic [7:0] idx, input logic [23:0] w);
        bus_wr(2'b00, idx);
        bus_wr(2'b01, w[23:16]);
        bus_wr(2'b01, w[15:8]);
        bus_wr(2'b01, w[7:0]);
    endtask

    task automatic t_reset();
        logic [7:0] b;
        logic [23:0] w;
        bus_rd(2'b00, b);
        check("R1 pointer after reset", {16'h0, b}, 24'h000000);
        bus_wr(2'b01, 8'h11);
        bus_wr(2'b01, 8'h22);
        bus_wr(2'b01, 8'h33);
        disp(8'h00, w);
        check("R1 first write lands red of entry 0", w, 24'h112233);
    endtask

    task automatic t_ptr();
        logic [7:0] b;
        bus_wr(2'b00, 8'hA5);
        bus_rd(2'b00, b);
        check("R2 pointer readback", {16'h0, b}, 24'h0000A5);
    endtask

    task automatic t_commit();
        logic [23:0] w;
        logic [7:0] b;
        put_entry(8'h05, 24'hAABBCC);
        bus_wr(2'b00, 8'h05);
        bus_wr(2'b01, 8'h01);
        bus_wr(2'b01, 8'h02);
        disp(8'h05, w);
        check("R5 no commit before blue", w, 24'hAABBCC);
        bus_wr(2'b01, 8'h03);
        disp(8'h05, w);
        check("R5 commit on blue", w, 24'h010203);
        bus_rd(2'b00, b);
        check("R6 pointer advanced after blue write", {16'h0, b}, 24'h000006);
    endtask

    task automatic t_sub_reset();
        logic [23:0] w;
        logic [7:0] b;
        bus_wr(2'b00, 8'h07);
        bus_wr(2'b01, 8'h99);
        put_entry(8'h07, 24'h445566);
        disp(8'h07, w);
        check("R3 pointer write restarts at red", w, 24'h445566);
        bus_wr(2'b00, 8'h08);
        bus_wr(2'b01, 8'h77);
        bus_wr(2'b01, 8'h78);
        bus_rd(2'b00, b);
        check("R3 pointer read mid-sequence", {16'h0, b}, 24'h000008);
        bus_wr(2'b01, 8'h12);
        bus_wr(2'b01, 8'h34);
        bus_wr(2'b01, 8'h56);
        disp(8'h08, w);
        check("R3 R4 pointer read restarts at red", w, 24'h123456);
    endtask

    task automatic t_wrap();
        logic [23:0] w;
        logic [7:0] b;
        put_entry(8'hFF, 24'h9ABCDE);
        bus_rd(2'b00, b);
        check("R6 write wrap FF to 00", {16'h0, b}, 24'h000000);
        disp(8'hFF, w);
        check("R5 entry FF contents", w, 24'h9ABCDE);
    endtask

    task automatic t_read();
        logic [7:0] r, g, bl, b;
        bus_wr(2'b00, 8'h05);
        bus_rd(2'b01, r);
        bus_rd(2'b01, g);
        bus_rd(2'b01, bl);
        check("R7 read order", {r, g, bl}, 24'h010203);
        bus_rd(2'b00, b);
        check("R6 pointer advanced after blue read", {16'h0, b}, 24'h000006);
        bus_wr(2'b00, 8'hFF);
        bus_rd(2'b01, r);
        bus_rd(2'b01, g);
        bus_rd(2'b01, bl);
        check("R7 read entry FF", {r, g, bl}, 24'h9ABCDE);
        bus_rd(2'b00, b);
        check("R6 read wrap FF to 00", {16'h0, b}, 24'h000000);
    endtask

    task automatic t_ignore();
        logic [23:0] w;
        logic [7:0] b;
        put_entry(8'h10, 24'h0F0F0F);
        bus_wr(2'b00, 8'h10);
        bus_wr(2'b01, 8'h21);
        bus_wr(2'b10, 8'hEE);
        bus_wr(2'b11, 8'hEE);
        bus_rd(2'b10, b);
        bus_rd(2'b11, b);
        @(negedge clk);
        cpu_we = 1'b1; cpu_csel = 2'b01; cpu_wdata = 8'hEE;
        @(negedge clk);
        @(negedge clk);
        disp(8'h10, w);
        check("R8 table untouched", w, 24'h0F0F0F);
        bus_wr(2'b01, 8'h22);
        bus_wr(2'b01, 8'h23);
        disp(8'h10, w);
        check("R8 step kept across ignored cycles", w, 24'h212223);
        bus_rd(2'b00, b);
        check("R8 pointer kept across ignored cycles", {16'h0, b}, 24'h000011);
    endtask

    task automatic t_collide();
        put_entry(8'h20, 24'h0A0B0C);
        bus_wr(2'b00, 8'h20);
        bus_wr(2'b01, 8'h01);
        bus_wr(2'b01, 8'h02);
        @(negedge clk);
        pix_idx = 8'h20;
        cpu_cs = 1'b1; cpu_we = 1'b1; cpu_csel = 2'b01; cpu_wdata = 8'h03;
        @(negedge clk);
        cpu_cs = 1'b0;
        check("R9 same-cycle read returns old word", pix_rgb, 24'h0A0B0C);
        @(negedge clk);
        check("R9 new word one clock later", pix_rgb, 24'h010203);
        pix_idx = 8'h05;
        @(negedge clk);
        check("R9 lookup latency one clock", pix_rgb, 24'h010203);
        pix_idx = 8'h07;
        @(negedge clk);
        check("R9 lookup follows index", pix_rgb, 24'h445566);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ptr();
        t_commit();
        t_sub_reset();
        t_wrap();
        t_read();
        t_ignore();
        t_collide();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule